// File: doc/BRIEF.md
# System Control Port Register Block

This block sits on a byte-wide I/O port bus of a legacy board and answers a fixed set of port addresses. Some ports hold control bits that leave the block as plain output levels: a soft-reset request, a little-endian mode flag, a disk activity light, a four-bit cache control value and an I/O map-type select. Two ports do not store anything. A write to either of them fires a one-clock toggle pulse toward one of two password-protected non-volatile memory banks.

Other ports return fixed identity and equipment codes. Two scratch bytes read back whatever was last written to them. Any other access inside the bus is unmapped. An unmapped read returns all ones, and any unmapped access raises a one-clock error strobe. Read data is registered and holds until the next read.

Top module: `sys_ctl_ports`

## Requirements
- R1: A synchronous active-high reset clears every stored bit and drives all outputs low, including ioRdData, softResetReq and decodeErr.
- R2: A write to port 0x0092 sets softResetReq from data bit 0 and littleEndian from data bit 1. A read of 0x0092 always returns 0x00.
- R3: A write to port 0x0808 sets diskLight to data bit 0.
- R4: A write to port 0x081C stores data bits 3:0 on sysCtrl. A read of 0x081C returns them zero-extended.
- R5: A write to port 0x0850 stores data bit 0 on ioMapNonContig (0 = contiguous, 1 = non-contiguous). A read of 0x0850 returns that bit in bit 0.
- R6: A write to 0x0810 raises lockPulse1 for exactly one clock, and a write to 0x0812 raises lockPulse2 for exactly one clock. Neither write changes any stored value.
- R7: Reads of the fixed ports return these values: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00 and 0x0823→0x03.
- R8: Writes to 0x0800, 0x0802 and 0x0803 are accepted without an error and have no effect.
- R9: Ports 0x0398 and 0x0399 are two independent scratch bytes that read back the last value written.
- R10: A read of any other port returns 0xFF, and any other read or write pulses decodeErr for one clock without changing state. Port 0x0814 counts as mapped: a read returns 0xFF and a write is a no-op, neither with an error. Port 0x0808 is write-only, so a read of it is unmapped.
- R11: ioRdData updates on the clock edge that samples ioRdEn and holds its value while ioRdEn is low. All output changes appear one clock after the strobe that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ioAddr | input | 16 | Port address |
| ioWrData | input | 8 | Write data |
| ioWrEn | input | 1 | Write strobe, one clock per access |
| ioRdEn | input | 1 | Read strobe, one clock per access |
| ioRdData | output | 8 | Registered read data |
| softResetReq | output | 1 | Soft-reset request level |
| littleEndian | output | 1 | Little-endian mode flag |
| diskLight | output | 1 | Disk activity light |
| sysCtrl | output | 4 | Cache control value |
| ioMapNonContig | output | 1 | I/O map type select |
| lockPulse1 | output | 1 | Toggle pulse for password bank 1 |
| lockPulse2 | output | 1 | Toggle pulse for password bank 2 |
| decodeErr | output | 1 | Unmapped access strobe |

## Verification
The embedded assertions check the following on every cycle:
- The reset and endian levels follow the last write to 0x0092.
- sysCtrl holds between writes to its own port.
- The two toggle pulses never coincide, and each traces back to a write to its own address.
- A 0x0092 read yields zero.
- The error strobe follows an access.

Only the bench scenarios can show the full address map at once: every fixed code, the all-ones return for unmapped ports, the silence of writes to the identity ports and of writes to the lock ports, and scratch bytes that stay independent of each other.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int SCR_N    = 2;
  localparam int SCR_IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1;
  localparam logic [ADDR_W-1:0] SCR_BASE = 16'h0398;

  localparam logic [ADDR_W-1:0] P_SPECIAL = 16'h0092;
  localparam logic [ADDR_W-1:0] P_CPUCFG  = 16'h0800;
  localparam logic [ADDR_W-1:0] P_FEAT    = 16'h0802;
  localparam logic [ADDR_W-1:0] P_STAT    = 16'h0803;
  localparam logic [ADDR_W-1:0] P_DISK    = 16'h0808;
  localparam logic [ADDR_W-1:0] P_EQUIP   = 16'h080C;
  localparam logic [ADDR_W-1:0] P_LOCK1   = 16'h0810;
  localparam logic [ADDR_W-1:0] P_LOCK2   = 16'h0812;
  localparam logic [ADDR_W-1:0] P_L2INV   = 16'h0814;
  localparam logic [ADDR_W-1:0] P_KEYLK   = 16'h0818;
  localparam logic [ADDR_W-1:0] P_SYSCTL  = 16'h081C;
  localparam logic [ADDR_W-1:0] P_L2STAT  = 16'h0823;
  localparam logic [ADDR_W-1:0] P_MAP     = 16'h0850;

  localparam logic [DATA_W-1:0] V_CPUCFG = 8'hEF;
  localparam logic [DATA_W-1:0] V_FEAT   = 8'hAD;
  localparam logic [DATA_W-1:0] V_STAT   = 8'hE0;
  localparam logic [DATA_W-1:0] V_EQUIP  = 8'h3C;
  localparam logic [DATA_W-1:0] V_EXTF   = 8'h39;
  localparam logic [DATA_W-1:0] V_L2STAT = 8'h03;

  typedef enum logic [3:0] {
    RS_ZERO, RS_CPUCFG, RS_FEAT, RS_STAT, RS_EQUIP, RS_EXTF,
    RS_SYSCTL, RS_L2STAT, RS_MAP, RS_SCRATCH, RS_ONES
  } rdSel_e;

  typedef struct packed {
    logic                 wrSpecial;
    logic                 wrDisk;
    logic                 wrSysCtl;
    logic                 wrMap;
    logic                 wrScratch;
    logic                 togLock1;
    logic                 togLock2;
    logic                 rdStb;
    rdSel_e               rdSel;
    logic [SCR_IDX_W-1:0] scrIdx;
    logic                 badAccess;
  } ctlStrobes_t;
endpackage

// File: rtl/sys_ctl_decode.sv
module sys_ctl_decode
  import sys_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output ctlStrobes_t       stb
);
  logic [ADDR_W-1:0] scrOff;
  logic              isScratch;
  logic              wrHit;
  logic              rdHit;

  assign scrOff    = ioAddr - SCR_BASE;
  assign isScratch = (ioAddr >= SCR_BASE) && (scrOff < ADDR_W'(SCR_N));

  always_comb begin
    stb        = '0;
    stb.rdSel  = RS_ONES;
    stb.scrIdx = scrOff[SCR_IDX_W-1:0];
    wrHit      = 1'b1;
    rdHit      = 1'b1;

    if (isScratch) begin
      stb.wrScratch = ioWrEn;
    end else begin
      unique case (ioAddr)
        P_SPECIAL: stb.wrSpecial = ioWrEn;
        P_DISK:    stb.wrDisk    = ioWrEn;
        P_SYSCTL:  stb.wrSysCtl  = ioWrEn;
        P_MAP:     stb.wrMap     = ioWrEn;
        P_LOCK1:   stb.togLock1  = ioWrEn;
        P_LOCK2:   stb.togLock2  = ioWrEn;
        P_CPUCFG, P_FEAT, P_STAT, P_L2INV: ;
        default:   wrHit = 1'b0;
      endcase
    end

    if (isScratch) begin
      stb.rdSel = RS_SCRATCH;
    end else begin
      unique case (ioAddr)
        P_SPECIAL, P_KEYLK: stb.rdSel = RS_ZERO;
        P_CPUCFG:  stb.rdSel = RS_CPUCFG;
        P_FEAT:    stb.rdSel = RS_FEAT;
        P_STAT:    stb.rdSel = RS_STAT;
        P_EQUIP:   stb.rdSel = RS_EQUIP;
        P_LOCK1:   stb.rdSel = RS_EXTF;
        P_SYSCTL:  stb.rdSel = RS_SYSCTL;
        P_L2STAT:  stb.rdSel = RS_L2STAT;
        P_MAP:     stb.rdSel = RS_MAP;
        P_L2INV:   stb.rdSel = RS_ONES;
        default:   rdHit = 1'b0;
      endcase
    end

    stb.rdStb     = ioRdEn;
    stb.badAccess = (ioWrEn && !wrHit) || (ioRdEn && !rdHit);
  end
endmodule

// File: rtl/sys_ctl_regs.sv
module sys_ctl_regs
  import sys_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              softResetReq,
  output logic              littleEndian,
  output logic              diskLight,
  output logic [3:0]        sysCtrl,
  output logic              ioMapNonContig,
  output logic              lockPulse1,
  output logic              lockPulse2,
  output logic              decodeErr
);
  logic [DATA_W-1:0] scratchQ [SCR_N];
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] scrRd;

  always_ff @(posedge clk) begin
    if (rst) begin
      softResetReq   <= 1'b0;
      littleEndian   <= 1'b0;
      diskLight      <= 1'b0;
      sysCtrl        <= 4'h0;
      ioMapNonContig <= 1'b0;
      lockPulse1     <= 1'b0;
      lockPulse2     <= 1'b0;
      decodeErr      <= 1'b0;
      rdData         <= '0;
    end else begin
      if (stb.wrSpecial) begin
        softResetReq <= wrData[0];
        littleEndian <= wrData[1];
      end
      if (stb.wrDisk)   diskLight      <= wrData[0];
      if (stb.wrSysCtl) sysCtrl        <= wrData[3:0];
      if (stb.wrMap)    ioMapNonContig <= wrData[0];
      lockPulse1 <= stb.togLock1;
      lockPulse2 <= stb.togLock2;
      decodeErr  <= stb.badAccess;
      if (stb.rdStb) rdData <= rdNext;
    end
  end

  for (genvar i = 0; i < SCR_N; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)
        scratchQ[i] <= '0;
      else if (stb.wrScratch && (stb.scrIdx == SCR_IDX_W'(i)))
        scratchQ[i] <= wrData;
    end
  end

  always_comb begin
    scrRd = '0;
    for (int i = 0; i < SCR_N; i++)
      if (stb.scrIdx == SCR_IDX_W'(i)) scrRd = scratchQ[i];
  end

  always_comb begin
    unique case (stb.rdSel)
      RS_ZERO:    rdNext = '0;
      RS_CPUCFG:  rdNext = V_CPUCFG;
      RS_FEAT:    rdNext = V_FEAT;
      RS_STAT:    rdNext = V_STAT;
      RS_EQUIP:   rdNext = V_EQUIP;
      RS_EXTF:    rdNext = V_EXTF;
      RS_SYSCTL:  rdNext = {{(DATA_W-4){1'b0}}, sysCtrl};
      RS_L2STAT:  rdNext = V_L2STAT;
      RS_MAP:     rdNext = {{(DATA_W-1){1'b0}}, ioMapNonContig};
      RS_SCRATCH: rdNext = scrRd;
      default:    rdNext = '1;
    endcase
  end

  // R6: the two toggle pulses come from distinct addresses and never coincide
  a_r6_lock_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(lockPulse1 && lockPulse2));
  // R10: an error strobe only follows a flagged access
  a_r10_err_source: assert property (@(posedge clk) disable iff (rst)
    decodeErr |-> $past(stb.badAccess));
  // R11: read data holds while no read is strobed
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.rdStb |=> $stable(rdData));
endmodule

// File: rtl/sys_ctl_ports.sv
module sys_ctl_ports
  import sys_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output logic [7:0]        ioRdData,
  output logic              softResetReq,
  output logic              littleEndian,
  output logic              diskLight,
  output logic [3:0]        sysCtrl,
  output logic              ioMapNonContig,
  output logic              lockPulse1,
  output logic              lockPulse2,
  output logic              decodeErr
);
  ctlStrobes_t stb;

  sys_ctl_decode u_decode (
    .ioAddr (ioAddr),
    .ioWrEn (ioWrEn),
    .ioRdEn (ioRdEn),
    .stb    (stb)
  );

  sys_ctl_regs u_regs (
    .clk            (clk),
    .rst            (rst),
    .stb            (stb),
    .wrData         (ioWrData),
    .rdData         (ioRdData),
    .softResetReq   (softResetReq),
    .littleEndian   (littleEndian),
    .diskLight      (diskLight),
    .sysCtrl        (sysCtrl),
    .ioMapNonContig (ioMapNonContig),
    .lockPulse1     (lockPulse1),
    .lockPulse2     (lockPulse2),
    .decodeErr      (decodeErr)
  );

  // R2: reset and endian levels follow a write to the special port
  a_r2_special_wr: assert property (@(posedge clk) disable iff (rst)
    (ioWrEn && ioAddr == P_SPECIAL) |=>
      (softResetReq == $past(ioWrData[0]) && littleEndian == $past(ioWrData[1])));
  // R2: special port reads zero
  a_r2_special_rd: assert property (@(posedge clk) disable iff (rst)
    (ioRdEn && ioAddr == P_SPECIAL) |=> (ioRdData == 8'h00));
  // R4: control nibble changes only through its own port
  a_r4_sysctl_hold: assert property (@(posedge clk) disable iff (rst)
    !(ioWrEn && ioAddr == P_SYSCTL) |=> $stable(sysCtrl));
  // R6: each pulse traces back to a write at its own address
  a_r6_lock1_src: assert property (@(posedge clk) disable iff (rst)
    lockPulse1 |-> $past(ioWrEn && ioAddr == P_LOCK1));
  a_r6_lock2_src: assert property (@(posedge clk) disable iff (rst)
    lockPulse2 |-> $past(ioWrEn && ioAddr == P_LOCK2));
  // R10: error strobe requires an access in the previous cycle
  a_r10_err_access: assert property (@(posedge clk) disable iff (rst)
    decodeErr |-> $past(ioWrEn || ioRdEn));
endmodule

// File: tb/tb_sys_ctl_ports.sv
module tb_sys_ctl_ports;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ioAddr;
  logic [7:0]  ioWrData;
  logic        ioWrEn;
  logic        ioRdEn;
  logic [7:0]  ioRdData;
  logic        softResetReq, littleEndian, diskLight, ioMapNonContig;
  logic [3:0]  sysCtrl;
  logic        lockPulse1, lockPulse2, decodeErr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  sys_ctl_ports dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrPort(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic rdPort(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
    d = ioRdData;
  endtask

  task automatic t_reset();
    check("R1 rdData", ioRdData, 0);
    check("R1 outputs", {softResetReq, littleEndian, diskLight, sysCtrl, ioMapNonContig,
                         lockPulse1, lockPulse2, decodeErr}, 0);
  endtask

  task automatic t_special();
    logic [7:0] d;
    wrPort(16'h0092, 8'h03);
    check("R2 set", {softResetReq, littleEndian}, 2'b11);
    check("R10 no err", decodeErr, 0);
    rdPort(16'h0092, d);
    check("R2 read zero", d, 8'h00);
    wrPort(16'h0092, 8'h02);
    check("R2 reset only low", {softResetReq, littleEndian}, 2'b01);
    wrPort(16'h0092, 8'hFC);
    check("R2 both low", {softResetReq, littleEndian}, 2'b00);
  endtask

  task automatic t_disk();
    wrPort(16'h0808, 8'h01);
    check("R3 on", diskLight, 1);
    wrPort(16'h0808, 8'hFE);
    check("R3 off", diskLight, 0);
  endtask

  task automatic t_sysctl_map();
    logic [7:0] d;
    wrPort(16'h081C, 8'hA5);
    check("R4 nibble", sysCtrl, 4'h5);
    rdPort(16'h081C, d);
    check("R4 readback", d, 8'h05);
    wrPort(16'h0850, 8'hFF);
    check("R5 map set", ioMapNonContig, 1);
    rdPort(16'h0850, d);
    check("R5 readback", d, 8'h01);
    wrPort(16'h0850, 8'h00);
    check("R5 map clear", ioMapNonContig, 0);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    wrPort(16'h0810, 8'hFF);
    check("R6 pulse1", {lockPulse1, lockPulse2}, 2'b10);
    @(negedge clk);
    check("R6 pulse1 one clock", lockPulse1, 0);
    wrPort(16'h0812, 8'hFF);
    check("R6 pulse2", {lockPulse1, lockPulse2}, 2'b01);
    @(negedge clk);
    check("R6 pulse2 one clock", lockPulse2, 0);
    check("R6 no state change", {sysCtrl, ioMapNonContig, diskLight}, {4'h5, 1'b0, 1'b0});
    rdPort(16'h0810, d);
    check("R6 lock port read", d, 8'h39);
  endtask

  task automatic t_fixed();
    logic [7:0] d;
    logic [15:0] addrs [7] = '{16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810, 16'h0818, 16'h0823};
    logic [7:0]  vals  [7] = '{8'hEF, 8'hAD, 8'hE0, 8'h3C, 8'h39, 8'h00, 8'h03};
    for (int i = 0; i < 7; i++) begin
      rdPort(addrs[i], d);
      check($sformatf("R7 fixed 0x%0h", addrs[i]), d, vals[i]);
    end
  endtask

  task automatic t_ro_writes();
    logic [7:0] d;
    wrPort(16'h0800, 8'h00);
    check("R8 no err", decodeErr, 0);
    wrPort(16'h0802, 8'h11);
    wrPort(16'h0803, 8'h22);
    rdPort(16'h0800, d);
    check("R8 cfg unchanged", d, 8'hEF);
    rdPort(16'h0803, d);
    check("R8 stat unchanged", d, 8'hE0);
    check("R8 outputs unchanged", {sysCtrl, softResetReq, littleEndian}, {4'h5, 2'b00});
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    wrPort(16'h0398, 8'h5A);
    wrPort(16'h0399, 8'hC3);
    rdPort(16'h0398, d);
    check("R9 scratch0", d, 8'h5A);
    rdPort(16'h0399, d);
    check("R9 scratch1", d, 8'hC3);
    wrPort(16'h0398, 8'h00);
    rdPort(16'h0399, d);
    check("R9 independent", d, 8'hC3);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rdPort(16'h0801, d);
    check("R10 read ones", d, 8'hFF);
    check("R10 read err", decodeErr, 1);
    @(negedge clk);
    check("R10 err one clock", decodeErr, 0);
    rdPort(16'h0808, d);
    check("R10 write-only read", {d, decodeErr}, {8'hFF, 1'b1});
    wrPort(16'h039A, 8'h77);
    check("R10 write err", decodeErr, 1);
    wrPort(16'h0851, 8'h0F);
    check("R10 no state change", {sysCtrl, ioMapNonContig}, {4'h5, 1'b0});
    rdPort(16'h0814, d);
    check("R10 0x814 read", {d, decodeErr}, {8'hFF, 1'b0});
    wrPort(16'h0814, 8'h00);
    check("R10 0x814 write", decodeErr, 0);
  endtask

  task automatic t_rd_timing();
    logic [7:0] d;
    rdPort(16'h0802, d);
    @(negedge clk);
    ioAddr = 16'h0800;
    @(negedge clk);
    check("R11 hold", ioRdData, 8'hAD);
    @(negedge clk);
    ioAddr = 16'h080C; ioRdEn = 1'b1;
    #1;
    check("R11 not before edge", ioRdData, 8'hAD);
    @(negedge clk);
    ioRdEn = 1'b0;
    check("R11 after edge", ioRdData, 8'h3C);
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; ioAddr = '0; ioWrData = '0; ioWrEn = 1'b0; ioRdEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_special();
    t_disk();
    t_sysctl_map();
    t_lock();
    t_fixed();
    t_ro_writes();
    t_scratch();
    t_unmapped();
    t_rd_timing();
    wrPort(16'h0092, 8'h01);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears request", {softResetReq, sysCtrl, ioRdData}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule